// File: doc/BRIEF.md
# SPI Slave Serial Front End with Hold Pause

This block is the pin-side front end of a serial memory slave that works in SPI mode 0. It oversamples chip select, serial clock, serial input and an active-low hold pin with a fast system clock. It assembles 8-bit units most significant bit first. It decodes the first unit of every frame as an op-code and hands each accepted byte to the memory back end with a tag that says whether it is the op-code, an address byte or a data byte. The back end supplies read bytes on request. The front end shifts those bytes out on the serial output, changing the bit after each falling serial-clock edge, and drives an enable for the external tri-state pin driver.

An op-code outside the supported set locks the frame out: the rest of the frame produces no bytes and no requests, and the output stays disabled until chip select is released and asserted again. The hold pin pauses a transfer. A pause starts or ends only when hold changes while the serial clock is low. While the block is paused, serial-clock edges are ignored and the output is disabled.

Top module: `spi_fe_top`

## Requirements
- R1: The serial input is sampled on rising serial-clock edges. The first rising edge after chip select falls carries bit 7 of the op-code. Each completed byte is reported by a one-cycle `rx_valid_o` pulse, with `rx_byte_o` holding the byte and `rx_kind_o` giving its kind (0 op-code, 1 address, 2 data).
- R2: Supported op-codes and the `cmd_o` code reported for each: 0x06 write-enable = 1, 0x04 write-disable = 2, 0x05 status read = 3, 0x01 status write = 4, 0x03 memory read = 5, 0x02 memory write = 6. `cmd_o` is 0 when no command is active. An accepted op-code is reported with kind 0.
- R3: While chip select is high, `so_oe_o` is 0, `cmd_o` returns to 0, and serial-clock edges produce no bytes. Raising chip select in the middle of a byte discards the partial byte and resets the bit position.
- R4: After an unsupported op-code, the rest of the frame produces no `rx_valid_o` and no `tx_req_o`, and `so_oe_o` stays 0. The next frame, after chip select toggles, is decoded normally.
- R5: Memory read and memory write are each followed by two address bytes of kind 1. Memory write then takes data bytes of kind 2 until chip select rises. Status write takes exactly one data byte of kind 2, and later bytes are ignored. After write-enable or write-disable, all further bytes are ignored.
- R6: For status read and memory read, `tx_req_o` pulses once when the last header byte completes and once after each output byte completes. `tx_byte_i` is sampled one clock after the pulse. That byte is shifted out most significant bit first, each bit changing after a falling serial-clock edge. `so_oe_o` is 1 from the first falling edge after the header until chip select rises.
- R7: Hold falling while the serial clock is low pauses the transfer. Hold rising while the serial clock is low resumes it. Serial-clock edges during the pause change no state, and `so_oe_o` is 0 while paused.
- R8: A change on hold while the serial clock is high has no effect: the transfer continues bit by bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the master |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold pause request, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial-out pin driver |
| rx_valid_o | output | 1 | One-cycle pulse: a received byte is valid |
| rx_byte_o | output | 8 | Received byte |
| rx_kind_o | output | 2 | Kind of received byte: 0 op-code, 1 address, 2 data |
| cmd_o | output | 3 | Command code of the current frame (see R2) |
| tx_req_o | output | 1 | One-cycle request for the next read byte |
| tx_byte_i | input | 8 | Read byte from the back end, sampled one clock after the request |

## Verification
The hardest state to reach from the ports is a hold pause that starts in the middle of an output byte. In that state the output enable must fall while the output bit is kept, and clock pulses sent during the pause must not shift anything. The stimulus reaches it by pausing at a random bit of a random byte in read and write frames, and by pulsing the serial clock with random input while paused. Any extra shift then shows up as corrupted bytes after the resume. Hold changes made while the clock is high are injected the same way, so that they span a whole bit. Frames aborted in the middle of a byte and unsupported op-codes followed by a valid frame cover the lockout and its release.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam logic [7:0] OPC_WEN   = 8'h06;
  localparam logic [7:0] OPC_WDIS  = 8'h04;
  localparam logic [7:0] OPC_RSTAT = 8'h05;
  localparam logic [7:0] OPC_WSTAT = 8'h01;
  localparam logic [7:0] OPC_RMEM  = 8'h03;
  localparam logic [7:0] OPC_WMEM  = 8'h02;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_WEN   = 3'd1,
    CMD_WDIS  = 3'd2,
    CMD_RSTAT = 3'd3,
    CMD_WSTAT = 3'd4,
    CMD_RMEM  = 3'd5,
    CMD_WMEM  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    KIND_OP   = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    PH_OP,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_IGNORE
  } phase_e;

  function automatic cmd_e decode_op(input logic [7:0] b);
    case (b)
      OPC_WEN:   return CMD_WEN;
      OPC_WDIS:  return CMD_WDIS;
      OPC_RSTAT: return CMD_RSTAT;
      OPC_WSTAT: return CMD_WSTAT;
      OPC_RMEM:  return CMD_RMEM;
      OPC_WMEM:  return CMD_WMEM;
      default:   return CMD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [WIDTH-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stg[g-1].q;
      end
    end
  end

  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_s_i,
  input  logic sck_s_i,
  input  logic hold_n_s_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic paused_o
);
  logic sck_d_q, hold_d_q, paused_q;
  logic hold_fell, hold_rose;

  assign hold_fell = hold_d_q & ~hold_n_s_i;
  assign hold_rose = ~hold_d_q & hold_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q  <= 1'b0;
      hold_d_q <= 1'b1;
      paused_q <= 1'b0;
    end else begin
      sck_d_q  <= sck_s_i;
      hold_d_q <= hold_n_s_i;
      if (cs_n_s_i)                   paused_q <= 1'b0;
      else if (hold_fell && !sck_s_i) paused_q <= 1'b1;
      else if (hold_rose && !sck_s_i) paused_q <= 1'b0;
    end
  end

  // clock edges count only inside a frame and outside a pause
  assign sck_rise_o = sck_s_i & ~sck_d_q & ~cs_n_s_i & ~paused_q;
  assign sck_fall_o = ~sck_s_i & sck_d_q & ~cs_n_s_i & ~paused_q;
  assign paused_o   = paused_q;
endmodule

// File: rtl/spi_fe_frame.sv
module spi_fe_frame
  import spi_fe_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_BYTES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              si_s_i,
  input  logic              rise_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic [1:0]        rx_kind_o,
  output logic [2:0]        cmd_o,
  output logic              tx_req_o,
  output logic              rd_phase_o,
  output logic              byte_start_o
);
  localparam int unsigned CNT_W  = $clog2(DATA_W);
  localparam int unsigned ACNT_W = $clog2(ADDR_BYTES + 1);

  phase_e              phase_q;
  cmd_e                cmd_q, dec;
  logic [CNT_W-1:0]    bit_q;
  logic [ACNT_W-1:0]   acnt_q;
  logic [DATA_W-1:0]   sh_q, byte_nxt, rx_byte_q;
  logic [1:0]          rx_kind_q;
  logic                rx_valid_q, tx_req_q, last_bit;

  assign byte_nxt = {sh_q[DATA_W-2:0], si_s_i};
  assign last_bit = (bit_q == CNT_W'(DATA_W - 1));

  always_comb dec = decode_op(byte_nxt[7:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_OP;
      cmd_q      <= CMD_NONE;
      bit_q      <= '0;
      acnt_q     <= '0;
      sh_q       <= '0;
      rx_byte_q  <= '0;
      rx_kind_q  <= KIND_OP;
      rx_valid_q <= 1'b0;
      tx_req_q   <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      tx_req_q   <= 1'b0;
      if (cs_n_s_i) begin
        phase_q <= PH_OP;
        cmd_q   <= CMD_NONE;
        bit_q   <= '0;
        acnt_q  <= '0;
      end else if (rise_i && phase_q != PH_IGNORE) begin
        bit_q <= last_bit ? '0 : bit_q + 1'b1;
        sh_q  <= byte_nxt;
        if (last_bit) begin
          case (phase_q)
            PH_OP: begin
              if (dec != CMD_NONE) begin
                cmd_q      <= dec;
                rx_valid_q <= 1'b1;
                rx_byte_q  <= byte_nxt;
                rx_kind_q  <= KIND_OP;
                case (dec)
                  CMD_RMEM, CMD_WMEM: begin
                    phase_q <= PH_ADDR;
                    acnt_q  <= ACNT_W'(ADDR_BYTES - 1);
                  end
                  CMD_WSTAT: phase_q <= PH_WDATA;
                  CMD_RSTAT: begin
                    phase_q  <= PH_RDATA;
                    tx_req_q <= 1'b1;
                  end
                  default:   phase_q <= PH_IGNORE;
                endcase
              end else begin
                phase_q <= PH_IGNORE;
              end
            end
            PH_ADDR: begin
              rx_valid_q <= 1'b1;
              rx_byte_q  <= byte_nxt;
              rx_kind_q  <= KIND_ADDR;
              if (acnt_q == '0) begin
                if (cmd_q == CMD_RMEM) begin
                  phase_q  <= PH_RDATA;
                  tx_req_q <= 1'b1;
                end else begin
                  phase_q <= PH_WDATA;
                end
              end else begin
                acnt_q <= acnt_q - 1'b1;
              end
            end
            PH_WDATA: begin
              rx_valid_q <= 1'b1;
              rx_byte_q  <= byte_nxt;
              rx_kind_q  <= KIND_DATA;
              if (cmd_q == CMD_WSTAT) phase_q <= PH_IGNORE;
            end
            PH_RDATA: tx_req_q <= 1'b1;
            default:  phase_q  <= PH_IGNORE;
          endcase
        end
      end
    end
  end

  assign rx_valid_o   = rx_valid_q;
  assign rx_byte_o    = rx_byte_q;
  assign rx_kind_o    = rx_kind_q;
  assign cmd_o        = cmd_q;
  assign tx_req_o     = tx_req_q;
  assign rd_phase_o   = (phase_q == PH_RDATA);
  assign byte_start_o = (bit_q == '0);
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              fall_i,
  input  logic              paused_i,
  input  logic              rd_phase_i,
  input  logic              byte_start_i,
  input  logic              tx_req_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              so_o,
  output logic              so_oe_o
);
  logic              cap_q, active_q, so_q, oe_q;
  logic [DATA_W-1:0] buf_q, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q    <= 1'b0;
      active_q <= 1'b0;
      so_q     <= 1'b0;
      oe_q     <= 1'b0;
      buf_q    <= '0;
      sh_q     <= '0;
    end else begin
      cap_q <= tx_req_i;
      if (cap_q) buf_q <= tx_byte_i;
      if (cs_n_s_i) begin
        active_q <= 1'b0;
        so_q     <= 1'b0;
      end else if (fall_i && rd_phase_i) begin
        active_q <= 1'b1;
        if (byte_start_i) begin
          so_q <= buf_q[DATA_W-1];
          sh_q <= {buf_q[DATA_W-2:0], 1'b0};
        end else begin
          so_q <= sh_q[DATA_W-1];
          sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end
      end
      oe_q <= active_q & ~paused_i & ~cs_n_s_i;
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = oe_q;
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
  import spi_fe_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_BYTES  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_ni,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic [1:0]        rx_kind_o,
  output logic [2:0]        cmd_o,
  output logic              tx_req_o,
  input  logic [DATA_W-1:0] tx_byte_i
);
  localparam int unsigned PINS = 4;

  logic [PINS-1:0] pins_s;
  logic cs_n_s, sck_s, si_s, hold_n_s;
  logic sck_rise, sck_fall, paused, rd_phase, byte_start;

  // pin order: hold, si, sck, cs
  spi_fe_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1001)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hold_ni, si_i, sck_i, cs_ni}),
    .q_o   (pins_s)
  );

  assign cs_n_s   = pins_s[0];
  assign sck_s    = pins_s[1];
  assign si_s     = pins_s[2];
  assign hold_n_s = pins_s[3];

  spi_fe_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_s_i  (cs_n_s),
    .sck_s_i   (sck_s),
    .hold_n_s_i(hold_n_s),
    .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall),
    .paused_o  (paused)
  );

  spi_fe_frame #(
    .DATA_W    (DATA_W),
    .ADDR_BYTES(ADDR_BYTES)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_s_i    (cs_n_s),
    .si_s_i      (si_s),
    .rise_i      (sck_rise),
    .rx_valid_o  (rx_valid_o),
    .rx_byte_o   (rx_byte_o),
    .rx_kind_o   (rx_kind_o),
    .cmd_o       (cmd_o),
    .tx_req_o    (tx_req_o),
    .rd_phase_o  (rd_phase),
    .byte_start_o(byte_start)
  );

  spi_fe_tx #(
    .DATA_W(DATA_W)
  ) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_s_i    (cs_n_s),
    .fall_i      (sck_fall),
    .paused_i    (paused),
    .rd_phase_i  (rd_phase),
    .byte_start_i(byte_start),
    .tx_req_i    (tx_req_o),
    .tx_byte_i   (tx_byte_i),
    .so_o        (so_o),
    .so_oe_o     (so_oe_o)
  );
endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_s,
  input logic              sck_s,
  input logic              paused,
  input logic              sck_rise,
  input logic              so_oe_o,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_byte_o,
  input logic [1:0]        rx_kind_o,
  input logic [2:0]        cmd_o,
  input logic              tx_req_o
);
  p_oe_off_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> !so_oe_o);

  p_oe_off_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused |=> !so_oe_o);

  p_pause_clk_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused) |-> $past(!sck_s));

  p_resume_clk_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(paused) |-> ($past(!sck_s) || $past(cs_n_s)));

  p_rx_after_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(sck_rise));

  p_op_known_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_kind_o == 2'd0) |->
      (rx_byte_o[7:0] inside {8'h06, 8'h04, 8'h05, 8'h01, 8'h03, 8'h02}));

  p_txreq_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (cmd_o == 3'd3 || cmd_o == 3'd5));
endmodule

bind spi_fe_top spi_fe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_n_s    (cs_n_s),
  .sck_s     (sck_s),
  .paused    (paused),
  .sck_rise  (sck_rise),
  .so_oe_o   (so_oe_o),
  .rx_valid_o(rx_valid_o),
  .rx_byte_o (rx_byte_o),
  .rx_kind_o (rx_kind_o),
  .cmd_o     (cmd_o),
  .tx_req_o  (tx_req_o)
);

// File: tb/spi_fe_top_tb_top.sv
`timescale 1ns/1ps
module spi_fe_top_tb_top;
  localparam int H = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, si_i = 1'b0, hold_ni = 1'b1;
  logic so_o, so_oe_o, rx_valid_o, tx_req_o;
  logic [7:0] rx_byte_o, tx_byte_i = 8'h00;
  logic [1:0] rx_kind_o;
  logic [2:0] cmd_o;

  int total = 0, bad = 0, cyc = 0, txreq_cnt = 0;
  bit done = 0, hold_oe_seen = 0;
  logic [9:0] rx_q[$];
  logic [7:0] tx_q[$];
  logic [2:0] cmd_at_op = 3'd0;

  always #2 clk_i = ~clk_i;

  spi_fe_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .si_i(si_i),
    .hold_ni(hold_ni), .so_o(so_o), .so_oe_o(so_oe_o), .rx_valid_o(rx_valid_o),
    .rx_byte_o(rx_byte_o), .rx_kind_o(rx_kind_o), .cmd_o(cmd_o),
    .tx_req_o(tx_req_o), .tx_byte_i(tx_byte_i)
  );

  // byte monitor and back-end model
  always @(negedge clk_i) begin
    if (rx_valid_o) begin
      rx_q.push_back({rx_kind_o, rx_byte_o});
      if (rx_kind_o == 2'd0) cmd_at_op = cmd_o;
    end
    if (tx_req_o) begin
      logic [7:0] v;
      v = 8'($urandom);
      tx_byte_i = v;
      tx_q.push_back(v);
      txreq_cnt++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk_i);
  endtask

  function automatic int decode(input logic [7:0] b);
    case (b)
      8'h06: return 1; 8'h04: return 2; 8'h05: return 3;
      8'h01: return 4; 8'h03: return 5; 8'h02: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_kind(input int cmd, input int k);
    if (cmd == 0) return -1;
    if (k == 0) return 0;
    case (cmd)
      4: return (k == 1) ? 2 : -1;
      5: return (k <= 2) ? 1 : -1;
      6: return (k <= 2) ? 1 : 2;
      default: return -1;
    endcase
  endfunction

  function automatic int hdr_len(input int cmd);
    if (cmd == 3) return 1;
    if (cmd == 5) return 3;
    return 0;
  endfunction

  // mode 1: pause while sck low at bit hb; mode 2: hold low while sck high from bit hb to hb-1
  task automatic send_byte(input logic [7:0] b, input int hb, input int mode,
                           output logic [7:0] rd, output logic [7:0] oe);
    for (int i = 7; i >= 0; i--) begin
      if (mode == 1 && hb == i) begin
        hold_ni = 1'b0;
        wait_h();
        if (so_oe_o) hold_oe_seen = 1;
        for (int p = 0; p < 3; p++) begin
          si_i = 1'($urandom);
          sck_i = 1'b1; wait_h();
          if (so_oe_o) hold_oe_seen = 1;
          sck_i = 1'b0; wait_h();
        end
        hold_ni = 1'b1;
        wait_h();
      end
      si_i = b[i];
      wait_h();
      rd[i] = so_o;
      oe[i] = so_oe_o;
      sck_i = 1'b1;
      if (mode == 2 && hb == i)     begin wait_h(); hold_ni = 1'b0; end
      if (mode == 2 && hb == i + 1) begin wait_h(); hold_ni = 1'b1; end
      wait_h();
      sck_i = 1'b0;
    end
  endtask

  task automatic do_frame(input logic [7:0] op, input int n_extra,
                          input int hbyte, input int hbit, input int mode);
    logic [7:0] mosi[8], rd[8], oeb[8];
    int cmd, hdr, n, idx, exp_tx;
    bit ok;
    string tg;
    rx_q.delete(); tx_q.delete(); txreq_cnt = 0; hold_oe_seen = 0; cmd_at_op = 3'd0;
    n = n_extra + 1;
    cmd = decode(op);
    hdr = hdr_len(cmd);
    cs_ni = 1'b0; wait_h();
    for (int k = 0; k < n; k++) begin
      mosi[k] = (k == 0) ? op : 8'($urandom);
      send_byte(mosi[k], (k == hbyte) ? hbit : -1, (k == hbyte) ? mode : 0, rd[k], oeb[k]);
    end
    wait_h();
    check(cmd_o == 3'(cmd), (cmd == 0) ? "R4 cmd_o held at none" : "R2 cmd_o in frame",
          int'(cmd_o), cmd);
    cs_ni = 1'b1;
    wait_h(); wait_h();
    // received byte stream
    tg = (cmd == 0) ? "R4 locked frame rx" : (mode == 2) ? "R8 rx under high-clock hold" :
         (mode == 1) ? "R7 rx across pause" : "R1 R5 rx stream";
    ok = 1; idx = 0;
    for (int k = 0; k < n; k++) begin
      int ek;
      ek = exp_kind(cmd, k);
      if (ek >= 0) begin
        if (idx >= rx_q.size()) ok = 0;
        else if (rx_q[idx] != {2'(ek), mosi[k]}) ok = 0;
        idx++;
      end
    end
    check(ok && idx == rx_q.size(), tg, rx_q.size(), idx);
    if (cmd != 0)
      check(cmd_at_op == 3'(cmd), "R2 op-code decode", int'(cmd_at_op), cmd);
    exp_tx = (hdr > 0 && n >= hdr) ? n - hdr + 1 : 0;
    check(txreq_cnt == exp_tx, (cmd == 0) ? "R4 no tx_req" : "R6 tx_req count", txreq_cnt, exp_tx);
    for (int k = 0; k < n; k++) begin
      if (hdr > 0 && k >= hdr) begin
        check(rd[k] == tx_q[k-hdr], "R6 read data", int'(rd[k]), int'(tx_q[k-hdr]));
        check(oeb[k] == 8'hFF, "R6 oe in read phase", int'(oeb[k]), 8'hFF);
      end else begin
        check(oeb[k] == 8'h00, (cmd == 0) ? "R4 oe off locked" : "R5 oe off", int'(oeb[k]), 0);
      end
    end
    if (mode == 1) check(!hold_oe_seen, "R7 oe off in pause", int'(hold_oe_seen), 0);
    check(!so_oe_o && cmd_o == 3'd0, "R3 idle after frame", {so_oe_o, cmd_o}, 0);
  endtask

  initial begin
    logic [7:0] ops[6];
    ops = '{8'h06, 8'h04, 8'h05, 8'h01, 8'h03, 8'h02};
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check(!so_oe_o && !rx_valid_o && !tx_req_o && cmd_o == 3'd0, "R3 reset state",
          {so_oe_o, rx_valid_o, tx_req_o, cmd_o}, 0);

    // clocks and data with chip select high
    rx_q.delete(); txreq_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      si_i = 1'($urandom); sck_i = 1'b1; wait_h(); sck_i = 1'b0; wait_h();
    end
    check(rx_q.size() == 0 && txreq_cnt == 0 && !so_oe_o, "R3 cs high ignored",
          rx_q.size() + txreq_cnt, 0);

    // directed frames
    do_frame(8'h06, 3, -1, -1, 0);
    do_frame(8'h04, 2, -1, -1, 0);
    do_frame(8'h05, 3, -1, -1, 0);
    do_frame(8'h01, 3, -1, -1, 0);
    do_frame(8'h03, 5, -1, -1, 0);
    do_frame(8'h02, 5, -1, -1, 0);
    do_frame(8'h03, 2, -1, -1, 0);
    do_frame(8'h00, 3, -1, -1, 0);
    do_frame(8'hA5, 4, -1, -1, 0);
    do_frame(8'h03, 1, -1, -1, 0);
    do_frame(8'h03, 5, 4, 3, 1);
    do_frame(8'h02, 4, 1, 5, 1);
    do_frame(8'h02, 4, 3, 4, 2);
    do_frame(8'h05, 2, 2, 7, 1);
    do_frame(8'h03, 4, 3, 0, 1);

    // cs released mid-byte
    rx_q.delete(); txreq_cnt = 0;
    cs_ni = 1'b0; wait_h();
    for (int i = 0; i < 4; i++) begin
      si_i = 1'($urandom); wait_h(); sck_i = 1'b1; wait_h(); sck_i = 1'b0;
    end
    wait_h(); cs_ni = 1'b1; wait_h(); wait_h();
    check(rx_q.size() == 0, "R3 partial byte discarded", rx_q.size(), 0);
    do_frame(8'h02, 3, -1, -1, 0);

    // random frames
    for (int f = 0; f < 30; f++) begin
      logic [7:0] op;
      int m, hb, hbit;
      op = ($urandom % 5 == 0) ? 8'($urandom) : ops[$urandom % 6];
      m = $urandom % 3;
      hb = $urandom % 4;
      hbit = (m == 2) ? 1 + ($urandom % 7) : $urandom % 8;
      do_frame(op, 1 + ($urandom % 5), hb, hbit, m);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule